// File: doc/BRIEF.md
# Memory Dependence Wait/Wake Tracker

This block holds the loads and stores of an out-of-order core between rename and issue. Each tracked instruction sits either in a waiting state or in a ready state. It becomes ready only when two separate conditions hold: its source registers are available, and any store it was predicted to depend on has issued. An external dependence predictor supplies the predicted producer store's sequence number at insert time. The block returns issue and violation information to that predictor on plain output ports.

Stores open a producer slot when they are inserted. A dependent load or store is linked to the slot of its producer. When the producer issues, every linked entry is released together. A separate release port frees non-speculative instructions, which otherwise never become ready. A squash port discards everything younger than a given sequence number. The issue port always offers the oldest ready instruction. Four counters record the inserted loads, the inserted stores, and the loads and stores that were linked to a producer.

Top module: `memdep_tracker`

## Requirements
- R1: An insert whose predicted producer is 0, or is not a store currently holding a producer slot, has no memory dependence. With registers ready it can issue in the next cycle. Without them it waits until a register wakeup for its sequence number arrives, and can issue in the cycle after that wakeup.
- R2: An insert whose predicted producer holds a slot is linked to that store. It becomes ready only after both the producer has issued and its registers are ready, in either order. Registers ready at insert count.
- R3: Issuing a store releases every entry linked to it. The released entries are visible on the issue port in the cycle after the store issues. Issuing a load releases nothing.
- R4: A register wakeup and the issue of the linked producer store may fall in the same cycle for the same entry. The entry is then ready in the next cycle.
- R5: An entry inserted with the non-speculative flag becomes ready only on a release for its sequence number. A register wakeup for it has no effect on the issue port.
- R6: While any entry is ready, issValid is high and issSeq carries the smallest ready sequence number. Taking it with issReq removes it. Ready entries stay ready until they issue or are squashed.
- R7: A squash with value S removes every entry and every producer slot whose sequence number is greater than S. Older entries keep their state. During a squash cycle, insReady and issValid are low and wakeups and releases are ignored.
- R8: insReady is low when all entry slots are in use. It is also low when the insert is a store and all producer slots are in use. A refused insert changes nothing.
- R9: violValid, violLoadPc and violStorePc are forwarded unchanged, in the same cycle, to predViolValid, predViolLoadPc and predViolStorePc.
- R10: cntLoads and cntStores count accepted inserts by kind. cntConfLoads and cntConfStores count the accepted loads and stores that were linked to a producer.
- R11: After reset the block is empty: issValid is low, insReady is high and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 1 | Insert request |
| insReady | output | 1 | Insert can be accepted this cycle |
| insSeq | input | SEQ_W | Sequence number of the inserted instruction |
| insIsStore | input | 1 | 1 = store, 0 = load |
| insRegsRdy | input | 1 | Source registers already available |
| insNonSpec | input | 1 | Instruction is non-speculative, waits for release |
| insPredSeq | input | SEQ_W | Predicted producer store, 0 = none |
| wakeValid | input | 1 | Register wakeup strobe |
| wakeSeq | input | SEQ_W | Sequence number whose registers became ready |
| relValid | input | 1 | Non-speculative release strobe |
| relSeq | input | SEQ_W | Sequence number to release |
| issReq | input | 1 | Consumer takes the offered instruction |
| issValid | output | 1 | A ready instruction is offered |
| issSeq | output | SEQ_W | Sequence number of the oldest ready instruction |
| issIsStore | output | 1 | Offered instruction is a store |
| sqValid | input | 1 | Squash strobe |
| sqSeq | input | SEQ_W | Keep entries at or below this sequence number |
| violValid | input | 1 | Memory-order violation detected |
| violLoadPc | input | PC_W | Address of the violating load |
| violStorePc | input | PC_W | Address of the conflicting store |
| predViolValid | output | 1 | Violation forwarded to the predictor |
| predViolLoadPc | output | PC_W | Forwarded load address |
| predViolStorePc | output | PC_W | Forwarded store address |
| cntLoads | output | CNT_W | Inserted loads |
| cntStores | output | CNT_W | Inserted stores |
| cntConfLoads | output | CNT_W | Loads linked to a producer |
| cntConfStores | output | CNT_W | Stores linked to a producer |

## Verification
The collision that matters is the issue of a producer store in the same cycle as a register wakeup for one of its dependents. The two events set different readiness flags of that one entry. The bench provokes it by raising issReq on the store together with wakeValid for a dependent whose registers were not yet ready. It then drains the ready set and expects all dependents in ascending order, including the one that received both events at once. A second collision pairs a squash with an insert and a pending issue. The bench judges it by insReady and issValid being low in that cycle, and by the refused instruction never appearing later.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

  // Strobes from the control to the two tables; each is already qualified.
  typedef struct packed {
    logic insFire;
    logic issFire;
    logic wakeEn;
    logic relEn;
    logic sqEn;
  } mdtStrobe_t;

endpackage

// File: rtl/mdt_ctrl.sv
module mdt_ctrl
  import mdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             insIsStore,
  input  logic             entryFree,
  input  logic             slotFree,
  input  logic             linkHit,
  input  logic             issReq,
  input  logic             anyReady,
  input  logic             wakeValid,
  input  logic             relValid,
  input  logic             sqValid,
  output mdtStrobe_t       strobe,
  output logic             insReady,
  output logic             issValid,
  output logic [CNT_W-1:0] cntLoads,
  output logic [CNT_W-1:0] cntStores,
  output logic [CNT_W-1:0] cntConfLoads,
  output logic [CNT_W-1:0] cntConfStores
);

  // Squash wins over every other operation in its cycle.
  assign insReady = entryFree && (!insIsStore || slotFree) && !sqValid;
  assign issValid = anyReady && !sqValid;

  always_comb begin
    strobe.insFire = insValid && insReady;
    strobe.issFire = issReq && issValid;
    strobe.wakeEn  = wakeValid && !sqValid;
    strobe.relEn   = relValid && !sqValid;
    strobe.sqEn    = sqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLoads      <= '0;
      cntStores     <= '0;
      cntConfLoads  <= '0;
      cntConfStores <= '0;
    end else if (strobe.insFire) begin
      if (insIsStore) begin
        cntStores <= cntStores + CNT_W'(1);
        if (linkHit) cntConfStores <= cntConfStores + CNT_W'(1);
      end else begin
        cntLoads <= cntLoads + CNT_W'(1);
        if (linkHit) cntConfLoads <= cntConfLoads + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/mdt_slots.sv
module mdt_slots
  import mdt_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdtStrobe_t       strobe,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic             insIsStore,
  input  logic             insNonSpec,
  input  logic [SEQ_W-1:0] insPredSeq,
  input  logic [SEQ_W-1:0] issSeq,
  input  logic             issIsStore,
  input  logic [SEQ_W-1:0] sqSeq,
  output logic             slotFree,
  output logic             linkHit,
  output logic [SW-1:0]    linkIdx,
  output logic             storeWake,
  output logic [SW-1:0]    storeWakeIdx
);

  logic [SLOTS-1:0] slotV;
  logic [SEQ_W-1:0] slotSeq [SLOTS];

  logic [SW-1:0] freeIdx, predIdx, issIdx;
  logic          predFound, issFound;
  logic          unusedBits;

  assign unusedBits = ^{strobe.wakeEn, strobe.relEn};

  always_comb begin
    slotFree  = 1'b0;
    freeIdx   = '0;
    predFound = 1'b0;
    predIdx   = '0;
    issFound  = 1'b0;
    issIdx    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!slotV[i] && !slotFree) begin
        slotFree = 1'b1;
        freeIdx  = SW'(i);
      end
      if (slotV[i] && slotSeq[i] == insPredSeq) begin
        predFound = 1'b1;
        predIdx   = SW'(i);
      end
      if (slotV[i] && slotSeq[i] == issSeq) begin
        issFound = 1'b1;
        issIdx   = SW'(i);
      end
    end
  end

  assign storeWake    = strobe.issFire && issIsStore && issFound;
  assign storeWakeIdx = issIdx;

  // A producer issuing in the insert cycle counts as already resolved.
  assign linkHit = !insNonSpec && (insPredSeq != '0) && predFound &&
                   !(storeWake && issIdx == predIdx);
  assign linkIdx = predIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotV <= '0;
      for (int i = 0; i < SLOTS; i++) slotSeq[i] <= '0;
    end else if (strobe.sqEn) begin
      for (int i = 0; i < SLOTS; i++)
        if (slotSeq[i] > sqSeq) slotV[i] <= 1'b0;
    end else begin
      if (storeWake) slotV[issIdx] <= 1'b0;
      if (strobe.insFire && insIsStore) begin
        slotV[freeIdx]   <= 1'b1;
        slotSeq[freeIdx] <= insSeq;
      end
    end
  end

endmodule

// File: rtl/mdt_entries.sv
module mdt_entries
  import mdt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 8,
  parameter int SEQ_W   = 16,
  localparam int EW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdtStrobe_t       strobe,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic             insIsStore,
  input  logic             insRegsRdy,
  input  logic             insNonSpec,
  input  logic             linkHit,
  input  logic [SW-1:0]    linkIdx,
  input  logic             storeWake,
  input  logic [SW-1:0]    storeWakeIdx,
  input  logic [SEQ_W-1:0] wakeSeq,
  input  logic [SEQ_W-1:0] relSeq,
  input  logic [SEQ_W-1:0] sqSeq,
  output logic             entryFree,
  output logic             anyReady,
  output logic [SEQ_W-1:0] selSeq,
  output logic             selIsStore
);

  logic [ENTRIES-1:0] eV, eRdy, eSt, eRegs, eMem, eLnk;
  logic [SEQ_W-1:0]   eSeq  [ENTRIES];
  logic [SW-1:0]      eSlot [ENTRIES];

  logic [EW-1:0] freeIdx, selIdx;

  always_comb begin
    entryFree = 1'b0;
    freeIdx   = '0;
    anyReady  = 1'b0;
    selIdx    = '0;
    selSeq    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!eV[i] && !entryFree) begin
        entryFree = 1'b1;
        freeIdx   = EW'(i);
      end
      if (eV[i] && eRdy[i] && (!anyReady || eSeq[i] < selSeq)) begin
        anyReady = 1'b1;
        selIdx   = EW'(i);
        selSeq   = eSeq[i];
      end
    end
  end

  assign selIsStore = eSt[selIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eV <= '0; eRdy <= '0; eSt <= '0; eRegs <= '0; eMem <= '0; eLnk <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        eSeq[i]  <= '0;
        eSlot[i] <= '0;
      end
    end else if (strobe.sqEn) begin
      for (int i = 0; i < ENTRIES; i++)
        if (eSeq[i] > sqSeq) eV[i] <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.issFire && selIdx == EW'(i)) begin
          eV[i]   <= 1'b0;
          eRdy[i] <= 1'b0;
        end else if (eV[i] && !eRdy[i]) begin
          logic regsNext, memNext, relHit;
          regsNext = eRegs[i] || (strobe.wakeEn && eSeq[i] == wakeSeq);
          memNext  = eMem[i] || (storeWake && eLnk[i] && eSlot[i] == storeWakeIdx);
          relHit   = strobe.relEn && eSeq[i] == relSeq;
          eRegs[i] <= regsNext;
          eMem[i]  <= memNext;
          if (memNext) eLnk[i] <= 1'b0;
          if ((regsNext && memNext) || relHit) eRdy[i] <= 1'b1;
        end
        if (strobe.insFire && freeIdx == EW'(i)) begin
          eV[i]    <= 1'b1;
          eSeq[i]  <= insSeq;
          eSt[i]   <= insIsStore;
          eLnk[i]  <= linkHit;
          eSlot[i] <= linkIdx;
          eRegs[i] <= insRegsRdy;
          eMem[i]  <= !insNonSpec && !linkHit;
          eRdy[i]  <= !insNonSpec && !linkHit && insRegsRdy;
        end
      end
    end
  end

endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import mdt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 8,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  output logic             insReady,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic             insIsStore,
  input  logic             insRegsRdy,
  input  logic             insNonSpec,
  input  logic [SEQ_W-1:0] insPredSeq,
  input  logic             wakeValid,
  input  logic [SEQ_W-1:0] wakeSeq,
  input  logic             relValid,
  input  logic [SEQ_W-1:0] relSeq,
  input  logic             issReq,
  output logic             issValid,
  output logic [SEQ_W-1:0] issSeq,
  output logic             issIsStore,
  input  logic             sqValid,
  input  logic [SEQ_W-1:0] sqSeq,
  input  logic             violValid,
  input  logic [PC_W-1:0]  violLoadPc,
  input  logic [PC_W-1:0]  violStorePc,
  output logic             predViolValid,
  output logic [PC_W-1:0]  predViolLoadPc,
  output logic [PC_W-1:0]  predViolStorePc,
  output logic [CNT_W-1:0] cntLoads,
  output logic [CNT_W-1:0] cntStores,
  output logic [CNT_W-1:0] cntConfLoads,
  output logic [CNT_W-1:0] cntConfStores
);

  mdtStrobe_t    strobe;
  logic          entryFree, slotFree, anyReady, linkHit, storeWake;
  logic [SW-1:0] linkIdx, storeWakeIdx;

  assign predViolValid   = violValid;
  assign predViolLoadPc  = violLoadPc;
  assign predViolStorePc = violStorePc;

  mdt_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk, .rstN, .insValid, .insIsStore, .entryFree, .slotFree, .linkHit,
    .issReq, .anyReady, .wakeValid, .relValid, .sqValid, .strobe,
    .insReady, .issValid, .cntLoads, .cntStores, .cntConfLoads, .cntConfStores
  );

  mdt_slots #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_slots (
    .clk, .rstN, .strobe, .insSeq, .insIsStore, .insNonSpec, .insPredSeq,
    .issSeq, .issIsStore, .sqSeq, .slotFree, .linkHit, .linkIdx,
    .storeWake, .storeWakeIdx
  );

  mdt_entries #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_entries (
    .clk, .rstN, .strobe, .insSeq, .insIsStore, .insRegsRdy, .insNonSpec,
    .linkHit, .linkIdx, .storeWake, .storeWakeIdx, .wakeSeq, .relSeq, .sqSeq,
    .entryFree, .anyReady, .selSeq(issSeq), .selIsStore(issIsStore)
  );

endmodule

// File: rtl/memdep_tracker_chk.sv
module memdep_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic             insReady,
  input logic             insIsStore,
  input logic             issValid,
  input logic             issReq,
  input logic             sqValid,
  input logic [CNT_W-1:0] cntLoads,
  input logic [CNT_W-1:0] cntStores,
  input logic [CNT_W-1:0] cntConfLoads
);

  AST_SQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> (!issValid && !insReady)); // R7

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issReq && !sqValid) |=> (issValid || sqValid)); // R6

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insReady && !insIsStore) |=> (cntLoads == $past(cntLoads) + CNT_W'(1))); // R10

  AST_REFUSED_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insReady) |=> (cntLoads == $past(cntLoads) && cntStores == $past(cntStores))); // R8

  AST_CONF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntConfLoads - $past(cntConfLoads)) <= CNT_W'(1)); // R10

endmodule

bind memdep_tracker memdep_tracker_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_memdep_tracker.sv
module test_memdep_tracker;

  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 0, insIsStore = 0, insRegsRdy = 0, insNonSpec = 0;
  logic [SEQ_W-1:0] insSeq = '0, insPredSeq = '0, wakeSeq = '0, relSeq = '0, sqSeq = '0;
  logic wakeValid = 0, relValid = 0, issReq = 0, sqValid = 0, violValid = 0;
  logic [PC_W-1:0] violLoadPc = '0, violStorePc = '0;
  logic insReady, issValid, issIsStore, predViolValid;
  logic [SEQ_W-1:0] issSeq;
  logic [PC_W-1:0] predViolLoadPc, predViolStorePc;
  logic [CNT_W-1:0] cntLoads, cntStores, cntConfLoads, cntConfStores;

  int nChk = 0, nBad = 0;
  int expQ[$];

  always #5 clk = ~clk;

  memdep_tracker i_memdep_tracker (
    .clk, .rstN, .insValid, .insReady, .insSeq, .insIsStore, .insRegsRdy,
    .insNonSpec, .insPredSeq, .wakeValid, .wakeSeq, .relValid, .relSeq,
    .issReq, .issValid, .issSeq, .issIsStore, .sqValid, .sqSeq, .violValid,
    .violLoadPc, .violStorePc, .predViolValid, .predViolLoadPc, .predViolStorePc,
    .cntLoads, .cntStores, .cntConfLoads, .cntConfStores
  );

  task automatic chk(string req, longint act, longint exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // Monitor: every instruction taken from the issue port must match the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rstN && issReq && issValid) begin
      nChk++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R6: actual issue %0d expected none", issSeq);
      end else begin
        int e;
        e = expQ.pop_front();
        if (issSeq !== SEQ_W'(e)) begin
          nBad++;
          $display("FAIL R6: actual issue %0d expected %0d", issSeq, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic ins(int seq, bit st, bit regs, bit ns, int pred);
    @(negedge clk);
    insValid = 1; insSeq = SEQ_W'(seq); insIsStore = st; insRegsRdy = regs;
    insNonSpec = ns; insPredSeq = SEQ_W'(pred);
    @(negedge clk);
    insValid = 0; insIsStore = 0; insRegsRdy = 0; insNonSpec = 0; insPredSeq = '0;
    #1;
  endtask

  task automatic wake(int seq);
    @(negedge clk); wakeValid = 1; wakeSeq = SEQ_W'(seq);
    @(negedge clk); wakeValid = 0; #1;
  endtask

  task automatic release_ns(int seq);
    @(negedge clk); relValid = 1; relSeq = SEQ_W'(seq);
    @(negedge clk); relValid = 0; #1;
  endtask

  task automatic squash(int seq);
    @(negedge clk); sqValid = 1; sqSeq = SEQ_W'(seq);
    @(negedge clk); sqValid = 0; #1;
  endtask

  // Take exactly one instruction, optionally with a register wakeup in the same cycle.
  task automatic issueOne(bit w, int wseq);
    @(negedge clk); issReq = 1; wakeValid = w; wakeSeq = SEQ_W'(wseq);
    @(negedge clk); issReq = 0; wakeValid = 0; #1;
  endtask

  task automatic drain(string req);
    @(negedge clk); issReq = 1;
    forever begin
      @(negedge clk); #1;
      if (!issValid) break;
    end
    issReq = 0;
    #2;
    chk({req, " scoreboard empty"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R11 reset state
    chk("R11 issValid", issValid, 0);
    chk("R11 insReady", insReady, 1);
    chk("R11 counters", cntLoads + cntStores + cntConfLoads + cntConfStores, 0);

    // R1 no dependence: ready now, or after register wakeup; pred 99 is untracked
    ins(5, 0, 1, 0, 0);
    chk("R1 ready insert offered", issSeq, 5);
    ins(7, 0, 0, 0, 99);
    expQ.push_back(5);
    drain("R1");
    chk("R1 waits for registers", issValid, 0);
    wake(7);
    chk("R1 ready after wakeup", issSeq, 7);
    expQ.push_back(7);
    drain("R1");

    // R2 / R3 linked dependent
    ins(10, 1, 0, 0, 0);
    ins(12, 0, 0, 0, 10);
    wake(12);
    chk("R2 registers alone not enough", issValid, 0);
    wake(10);
    chk("R2 producer offered", issSeq, 10);
    expQ.push_back(10);
    issueOne(0, 0);
    chk("R3 dependent visible next cycle", issValid, 1);
    chk("R3 dependent seq", issSeq, 12);
    expQ.push_back(12);
    drain("R3");

    // R4 wakeup and producer issue collide; R3 several dependents
    ins(20, 1, 0, 0, 0);
    ins(21, 0, 1, 0, 20);
    ins(22, 0, 0, 0, 20);
    ins(23, 1, 1, 0, 20);
    chk("R2 linked entries wait", issValid, 0);
    wake(20);
    expQ.push_back(20);
    issueOne(1, 22);
    expQ.push_back(21); expQ.push_back(22); expQ.push_back(23);
    drain("R4");

    // R5 non-speculative
    ins(30, 0, 1, 1, 0);
    chk("R5 waits at insert", issValid, 0);
    wake(30);
    chk("R5 wakeup no effect", issValid, 0);
    release_ns(30);
    chk("R5 release readies", issSeq, 30);
    expQ.push_back(30);
    drain("R5");

    // R6 oldest first
    ins(44, 0, 1, 0, 0);
    ins(41, 0, 1, 0, 0);
    ins(43, 0, 1, 0, 0);
    expQ.push_back(41); expQ.push_back(43); expQ.push_back(44);
    drain("R6");

    // R7 squash, with a colliding insert and pending issue
    ins(50, 1, 0, 0, 0);
    ins(51, 0, 1, 0, 50);
    ins(60, 0, 1, 0, 0);
    ins(45, 0, 1, 0, 0);
    @(negedge clk);
    sqValid = 1; sqSeq = 50; issReq = 1;
    insValid = 1; insSeq = 40; insRegsRdy = 1;
    #1;
    chk("R7 insReady low in squash", insReady, 0);
    chk("R7 issValid low in squash", issValid, 0);
    @(negedge clk);
    sqValid = 0; issReq = 0; insValid = 0; insRegsRdy = 0;
    #1;
    expQ.push_back(45);
    drain("R7");
    chk("R7 older waiting store kept", issValid, 0);
    wake(50);
    expQ.push_back(50);
    drain("R7");
    chk("R7 squashed dependent gone", issValid, 0);
    ins(70, 1, 0, 0, 0);
    squash(65);
    ins(71, 0, 1, 0, 70);
    chk("R7 squashed slot not a producer", issSeq, 71);
    expQ.push_back(71);
    drain("R7");
    chk("R7 squashed store gone", issValid, 0);

    // R10 counters
    chk("R10 loads", cntLoads, 13);
    chk("R10 stores", cntStores, 5);
    chk("R10 conflicting loads", cntConfLoads, 4);
    chk("R10 conflicting stores", cntConfStores, 1);

    // R8 back-pressure: entries full
    for (int i = 0; i < 16; i++) ins(100 + i, 0, 0, 0, 0);
    chk("R8 entries full", insReady, 0);
    squash(0);
    chk("R8 space after flush", insReady, 1);
    for (int i = 0; i < 8; i++) ins(200 + i, 1, 0, 0, 0);
    @(negedge clk);
    insIsStore = 1; #1;
    chk("R8 store refused slots full", insReady, 0);
    insIsStore = 0; #1;
    chk("R8 load accepted slots full", insReady, 1);
    squash(0);

    // R9 violation forwarding
    @(negedge clk);
    violValid = 1; violLoadPc = 32'h1234_5678; violStorePc = 32'h0000_abcd; #1;
    chk("R9 valid", predViolValid, 1);
    chk("R9 load pc", predViolLoadPc, 32'h1234_5678);
    chk("R9 store pc", predViolStorePc, 32'h0000_abcd);
    violValid = 0;

    finishRun();
  end

endmodule